// File: doc/BRIEF.md
# Three-Channel Serial Register Front End

This block is the register side of three byte-oriented serial channels. A single-cycle register bus reaches every channel's control word, interrupt-mode byte, transmit byte, receive byte and status word. The last channel also holds one extra timer byte. Each access is decoded and checked against the register it targets: its transfer size, its direction and any read-only bits. The result, either read data or an error flag, returns combinationally in the same cycle as the access. An access that fails a check changes nothing.

On the line side, each channel takes in one received byte per valid strobe. The byte is held in the receive buffer, and a ready flag in status bit 4 tells software that a byte is waiting. A successful transmit-buffer write sends the byte out for one cycle on the channel's transmit strobe. Each channel also gives one-cycle receive and transmit event pulses, which an interrupt controller elsewhere can use.

Top module: `triple_serial_regs`

## Requirements
- R1: After reset, every control, interrupt-mode, transmit, receive, status and timer register reads as zero, and no strobe or event output is high.
- R2: Channel c (0..2) decodes at base 0x10·c: control +0x0, interrupt mode +0x4, transmit +0x8, receive +0x9, status +0xC. The timer byte sits at 0x2D only. Any other address, including 0x1D and channel index 3, raises the error flag.
- R3: Control is a 16-bit word. wdata_i[7:0] is its low byte, the one at the lower address. Control accepts only size_i = 2. Interrupt mode, transmit, receive and timer accept only size_i = 1. A size of 0 or 3 is always an error.
- R4: A control write to channel 2 whose data has any bit of 0x0C04 set is an error and leaves the register unchanged. Channels 0 and 1 accept those bits.
- R5: An interrupt-mode write is an error if its byte has a bit set under 0xCA on channel 2, or under 0x4A on channels 0 and 1. The register then keeps its old value.
- R6: A receive strobe loads the byte into the receive buffer and sets status bit 4 (value 0x0010). The channel's receive event is high in the following cycle.
- R7: A receive-buffer read returns the byte and clears the ready flag. A new byte that arrives while the flag is set overwrites the buffer and keeps the flag set. If a read and an arrival fall in the same cycle, the read returns the old byte, and the new byte and the set flag remain.
- R8: A status read of size 1 returns the low byte. A status read of size 2 returns the whole word, except on channel 2, where it is an error.
- R9: Any write to a receive buffer or to a status register is an error.
- R10: A transmit write stores the byte, which reads back. In the next cycle the channel's transmit strobe and transmit event are high for one cycle, with the byte on that channel's lane of tx_data_o.
- R11: When err_o is high, rdata_o is zero, and the access leaves no register, flag or strobe changed. Write accesses return zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset |
| size_i | input | 2 | Transfer size in bytes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, same cycle |
| err_o | output | 1 | Access rejected, same cycle |
| rx_valid_i | input | 3 | Per-channel received-byte strobe |
| rx_data_i | input | 24 | Received bytes, channel c at bits 8c+7:8c |
| tx_valid_o | output | 3 | Per-channel transmit strobe |
| tx_data_o | output | 24 | Transmit bytes, channel c at bits 8c+7:8c |
| rx_evt_o | output | 3 | Receive event pulse |
| tx_evt_o | output | 3 | Transmit event pulse |

## Verification
A byte arrival and a software read of the receive buffer can fall in the same cycle, and both act on the ready flag and the buffer. The bench makes this happen by driving a receive strobe together with a receive-buffer read while the flag is already set. It expects the read to return the older byte. Later status and buffer reads must then show the flag still set and the newer byte in the buffer. Back-to-back arrivals with no read between them check the overwrite case.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_IMODE, SEL_TXB, SEL_RXB, SEL_STAT, SEL_TIM
  } reg_sel_e;

  localparam int unsigned RDY_BIT      = 4;
  localparam logic [15:0] CTRL_RO_EXT  = 16'h0C04;
  localparam logic [7:0]  IMODE_RO_STD = 8'h4A;
  localparam logic [7:0]  IMODE_RO_EXT = 8'hCA;
endpackage

// File: rtl/ser_decode.sv
module ser_decode
  import ser_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned EXT_CH = 2,
  localparam int unsigned CH_W  = ADDR_W - 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [15:0]       wdata_i,
  output reg_sel_e          sel_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              hit_o,
  output logic              err_o
);
  logic [CH_W-1:0] ch_raw;
  logic [3:0]      loc;
  logic            in_range, is_ext, bad;
  reg_sel_e        sel;

  assign ch_raw   = addr_i[ADDR_W-1:4];
  assign loc      = addr_i[3:0];
  assign in_range = 32'(ch_raw) < NUM_CH;
  assign is_ext   = 32'(ch_raw) == EXT_CH;

  always_comb begin
    sel = SEL_NONE;
    if (in_range) begin
      case (loc)
        4'h0:    sel = SEL_CTRL;
        4'h4:    sel = SEL_IMODE;
        4'h8:    sel = SEL_TXB;
        4'h9:    sel = SEL_RXB;
        4'hC:    sel = SEL_STAT;
        4'hD:    sel = is_ext ? SEL_TIM : SEL_NONE;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  bad = (size_i != 2'd2) || (we_i && is_ext && |(wdata_i & CTRL_RO_EXT));
      SEL_IMODE: bad = (size_i != 2'd1) ||
                       (we_i && |(wdata_i[7:0] & (is_ext ? IMODE_RO_EXT : IMODE_RO_STD)));
      SEL_TXB,
      SEL_TIM:   bad = (size_i != 2'd1);
      SEL_RXB:   bad = (size_i != 2'd1) || we_i;
      SEL_STAT:  bad = we_i || !((size_i == 2'd1) || (size_i == 2'd2 && !is_ext));
      default:   bad = 1'b1;
    endcase
  end

  assign sel_o = sel;
  assign ch_o  = ch_raw;
  assign hit_o = req_i && !bad;
  assign err_o = req_i && bad;
endmodule

// File: rtl/ser_channel.sv
module ser_channel (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_ctrl_i,
  input  logic        wr_imode_i,
  input  logic        wr_txb_i,
  input  logic        rd_rxb_i,
  input  logic [15:0] wdata_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic [15:0] ctrl_o,
  output logic [7:0]  imode_o,
  output logic [7:0]  txb_o,
  output logic [7:0]  rxb_o,
  output logic        rdy_o,
  output logic        tx_valid_o,
  output logic        rx_evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      imode_o    <= '0;
      txb_o      <= '0;
      rxb_o      <= '0;
      rdy_o      <= 1'b0;
      tx_valid_o <= 1'b0;
      rx_evt_o   <= 1'b0;
    end else begin
      if (wr_ctrl_i)  ctrl_o  <= wdata_i;
      if (wr_imode_i) imode_o <= wdata_i[7:0];
      if (wr_txb_i)   txb_o   <= wdata_i[7:0];
      tx_valid_o <= wr_txb_i;
      rx_evt_o   <= rx_valid_i;
      // arrival beats a same-cycle read
      if (rx_valid_i) begin
        rxb_o <= rx_data_i;
        rdy_o <= 1'b1;
      end else if (rd_rxb_i) begin
        rdy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/triple_serial_regs.sv
module triple_serial_regs
  import ser_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned EXT_CH = 2,
  localparam int unsigned CH_W  = ADDR_W - 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          size_i,
  input  logic [15:0]         wdata_i,
  output logic [15:0]         rdata_o,
  output logic                err_o,
  input  logic [NUM_CH-1:0]   rx_valid_i,
  input  logic [NUM_CH*8-1:0] rx_data_i,
  output logic [NUM_CH-1:0]   tx_valid_o,
  output logic [NUM_CH*8-1:0] tx_data_o,
  output logic [NUM_CH-1:0]   rx_evt_o,
  output logic [NUM_CH-1:0]   tx_evt_o
);
  reg_sel_e        sel;
  logic [CH_W-1:0] ch;
  logic            hit;
  logic [15:0]     ctrl  [NUM_CH];
  logic [7:0]      imode [NUM_CH];
  logic [7:0]      txb   [NUM_CH];
  logic [7:0]      rxb   [NUM_CH];
  logic [NUM_CH-1:0] rdy;
  logic [7:0]      tim_q;
  logic [15:0]     stat;

  ser_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .EXT_CH(EXT_CH)) u_dec (
    .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .sel_o(sel), .ch_o(ch), .hit_o(hit), .err_o(err_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_ch;
    assign sel_ch = hit && (32'(ch) == c);
    ser_channel u_ch (
      .clk_i, .rst_ni,
      .wr_ctrl_i (sel_ch && we_i && sel == SEL_CTRL),
      .wr_imode_i(sel_ch && we_i && sel == SEL_IMODE),
      .wr_txb_i  (sel_ch && we_i && sel == SEL_TXB),
      .rd_rxb_i  (sel_ch && !we_i && sel == SEL_RXB),
      .wdata_i,
      .rx_valid_i(rx_valid_i[c]),
      .rx_data_i (rx_data_i[8*c +: 8]),
      .ctrl_o    (ctrl[c]),
      .imode_o   (imode[c]),
      .txb_o     (txb[c]),
      .rxb_o     (rxb[c]),
      .rdy_o     (rdy[c]),
      .tx_valid_o(tx_valid_o[c]),
      .rx_evt_o  (rx_evt_o[c])
    );
    assign tx_data_o[8*c +: 8] = txb[c];
  end

  assign tx_evt_o = tx_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tim_q <= '0;
    else if (hit && we_i && sel == SEL_TIM) tim_q <= wdata_i[7:0];
  end

  assign stat = 16'(rdy[ch]) << RDY_BIT;

  always_comb begin
    rdata_o = '0;
    if (hit && !we_i) begin
      case (sel)
        SEL_CTRL:  rdata_o = ctrl[ch];
        SEL_IMODE: rdata_o = {8'h00, imode[ch]};
        SEL_TXB:   rdata_o = {8'h00, txb[ch]};
        SEL_RXB:   rdata_o = {8'h00, rxb[ch]};
        SEL_STAT:  rdata_o = (size_i == 2'd1) ? {8'h00, stat[7:0]} : stat;
        SEL_TIM:   rdata_o = {8'h00, tim_q};
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/triple_serial_regs_chk.sv
module triple_serial_regs_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NUM_CH = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [1:0]          size_i,
  input logic [15:0]         wdata_i,
  input logic [15:0]         rdata_o,
  input logic                err_o,
  input logic [NUM_CH-1:0]   rx_valid_i,
  input logic [NUM_CH-1:0]   tx_valid_o,
  input logic [NUM_CH*8-1:0] tx_data_o,
  input logic [NUM_CH-1:0]   rx_evt_o
);
  // R11
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == 16'h0000);

  // R3
  bad_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (size_i == 2'd0 || size_i == 2'd3) |-> err_o);

  // R9
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && (addr_i[3:0] == 4'h9 || addr_i[3:0] == 4'hC) |-> err_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6
    rx_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_i[c] |=> rx_evt_o[c]);

    // R10
    tx_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i && we_i && !err_o && addr_i == ADDR_W'(16*c + 8)
      |=> tx_valid_o[c] && tx_data_o[8*c +: 8] == $past(wdata_i[7:0]));
  end
endmodule

bind triple_serial_regs triple_serial_regs_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i, .rdata_o, .err_o,
  .rx_valid_i, .tx_valid_o, .tx_data_o, .rx_evt_o
);

// File: tb/triple_serial_regs_test.sv
module triple_serial_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        err_o;
  logic [2:0]  rx_valid_i = '0;
  logic [23:0] rx_data_i = '0;
  logic [2:0]  tx_valid_o, rx_evt_o, tx_evt_o;
  logic [23:0] tx_data_o;

  int n_chk = 0, n_err = 0;
  logic        q_err [$];
  logic [15:0] q_dat [$];
  string       q_tag [$];

  always #2.5 clk_i = ~clk_i;

  triple_serial_regs uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each access against the scoreboard
  always @(negedge clk_i) begin
    if (req_i) begin
      if (q_tag.size() == 0) chk(1'b0, "scoreboard-empty", 0, 1);
      else begin
        logic e; logic [15:0] d; string t;
        e = q_err.pop_front(); d = q_dat.pop_front(); t = q_tag.pop_front();
        chk(err_o == e, {t, " err"}, 32'(err_o), 32'(e));
        chk(rdata_o == d, {t, " rdata"}, 32'(rdata_o), 32'(d));
      end
    end
  end

  task automatic acc(input bit we, input logic [5:0] a, input logic [1:0] sz,
                     input logic [15:0] wd, input bit exp_err, input logic [15:0] exp_d,
                     input string tag, input logic [2:0] rxv = 3'b0, input logic [23:0] rxd = '0);
    @(posedge clk_i); #1;
    req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; wdata_i = wd;
    rx_valid_i = rxv; rx_data_i = rxd;
    q_err.push_back(exp_err); q_dat.push_back(exp_d); q_tag.push_back(tag);
    @(posedge clk_i); #1;
    req_i = 1'b0; rx_valid_i = '0;
  endtask

  task automatic rx_push(input int c, input logic [7:0] b, input string tag);
    @(posedge clk_i); #1;
    rx_valid_i = 3'b1 << c; rx_data_i = 24'(b) << (8*c);
    @(posedge clk_i); #1;
    rx_valid_i = '0;
    chk(rx_evt_o == 3'(3'b1 << c), tag, 32'(rx_evt_o), 32'(3'b1 << c));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk(tx_valid_o == 0 && rx_evt_o == 0 && tx_evt_o == 0, "R1 strobes", 32'({tx_valid_o, rx_evt_o}), 0);
    acc(0, 6'h00, 2, 0, 0, 16'h0000, "R1 ctrl0");
    acc(0, 6'h14, 1, 0, 0, 16'h0000, "R1 imode1");
    acc(0, 6'h2C, 1, 0, 0, 16'h0000, "R1 stat2");
    acc(0, 6'h09, 1, 0, 0, 16'h0000, "R1 rxb0");
    acc(0, 6'h2D, 1, 0, 0, 16'h0000, "R1 tim");
    // R3 sizes and 16-bit control
    acc(1, 6'h00, 2, 16'hA55A, 0, 0, "R3 ctrl0 wr");
    acc(0, 6'h00, 2, 0, 0, 16'hA55A, "R3 ctrl0 rd");
    acc(1, 6'h10, 1, 16'h0011, 1, 0, "R3 ctrl1 size1");
    acc(0, 6'h04, 2, 0, 1, 0, "R3 imode size2");
    acc(0, 6'h08, 2, 0, 1, 0, "R3 txb size2");
    acc(0, 6'h0C, 0, 0, 1, 0, "R3 size0");
    acc(0, 6'h00, 3, 0, 1, 0, "R3 size3");
    // R2 map
    acc(0, 6'h02, 2, 0, 1, 0, "R2 hole");
    acc(0, 6'h3C, 1, 0, 1, 0, "R2 ch3");
    acc(1, 6'h1D, 1, 16'h0055, 1, 0, "R2 tim ch1");
    acc(1, 6'h2D, 1, 16'h007E, 0, 0, "R2 tim wr");
    acc(0, 6'h2D, 1, 0, 0, 16'h007E, "R2 tim rd");
    // R4 control masks
    acc(1, 6'h20, 2, 16'h0004, 1, 0, "R4 ctrl2 bit2");
    acc(0, 6'h20, 2, 0, 0, 16'h0000, "R4 ctrl2 kept");
    acc(1, 6'h20, 2, 16'h1230, 0, 0, "R4 ctrl2 ok");
    acc(1, 6'h20, 2, 16'h0800, 1, 0, "R4 ctrl2 bit11");
    acc(0, 6'h20, 2, 0, 0, 16'h1230, "R4 ctrl2 kept2");
    acc(1, 6'h10, 2, 16'h0C04, 0, 0, "R4 ctrl1 ok");
    acc(0, 6'h10, 2, 0, 0, 16'h0C04, "R4 ctrl1 rd");
    // R5 interrupt-mode masks
    acc(1, 6'h04, 1, 16'h0080, 0, 0, "R5 imode0 wr");
    acc(0, 6'h04, 1, 0, 0, 16'h0080, "R5 imode0 rd");
    acc(1, 6'h24, 1, 16'h0080, 1, 0, "R5 imode2 bit7");
    acc(0, 6'h24, 1, 0, 0, 16'h0000, "R5 imode2 kept");
    acc(1, 6'h14, 1, 16'h0002, 1, 0, "R5 imode1 bit1");
    acc(1, 6'h24, 1, 16'h0035, 0, 0, "R5 imode2 ok");
    acc(0, 6'h24, 1, 0, 0, 16'h0035, "R5 imode2 rd");
    // R10 transmit
    acc(1, 6'h18, 1, 16'h005C, 0, 0, "R10 txb1 wr");
    chk(tx_valid_o == 3'b010 && tx_evt_o == 3'b010, "R10 strobe", 32'({tx_valid_o, tx_evt_o}), 32'h12);
    chk(tx_data_o[15:8] == 8'h5C, "R10 data", 32'(tx_data_o[15:8]), 32'h5C);
    @(posedge clk_i); #1;
    chk(tx_valid_o == 0 && tx_evt_o == 0, "R10 one cycle", 32'({tx_valid_o, tx_evt_o}), 0);
    acc(0, 6'h18, 1, 0, 0, 16'h005C, "R10 txb1 rd");
    // R11 rejected transmit: no strobe
    acc(1, 6'h28, 2, 16'h0066, 1, 0, "R11 txb2 size2");
    chk(tx_valid_o == 0, "R11 no strobe", 32'(tx_valid_o), 0);
    acc(0, 6'h28, 1, 0, 0, 16'h0000, "R11 txb2 kept");
    // R6 receive
    rx_push(0, 8'h41, "R6 rx_evt0");
    acc(0, 6'h0C, 2, 0, 0, 16'h0010, "R6 stat0 word");
    acc(0, 6'h0C, 1, 0, 0, 16'h0010, "R8 stat0 byte");
    // R7 read clears, overwrite, same-cycle
    acc(0, 6'h09, 1, 0, 0, 16'h0041, "R7 rxb0 rd");
    acc(0, 6'h0C, 1, 0, 0, 16'h0000, "R7 rdy cleared");
    rx_push(0, 8'h42, "R6 rx_evt0 b");
    rx_push(0, 8'h43, "R7 overwrite evt");
    acc(0, 6'h0C, 1, 0, 0, 16'h0010, "R7 rdy kept");
    acc(0, 6'h09, 1, 0, 0, 16'h0043, "R7 same-cycle old byte", 3'b001, 24'h000044);
    acc(0, 6'h0C, 1, 0, 0, 16'h0010, "R7 same-cycle rdy");
    acc(0, 6'h09, 1, 0, 0, 16'h0044, "R7 same-cycle new byte");
    acc(0, 6'h0C, 1, 0, 0, 16'h0000, "R7 rdy cleared again");
    // R8 channel-2 status width
    rx_push(2, 8'h9A, "R6 rx_evt2");
    acc(0, 6'h2C, 2, 0, 1, 0, "R8 stat2 word");
    acc(0, 6'h2C, 1, 0, 0, 16'h0010, "R8 stat2 byte");
    // R9 read-only targets, R11 no side effect
    acc(1, 6'h29, 1, 16'h0000, 1, 0, "R9 rxb2 wr");
    acc(1, 6'h1C, 1, 16'h0010, 1, 0, "R9 stat1 wr");
    acc(0, 6'h1C, 1, 0, 0, 16'h0000, "R11 stat1 kept");
    acc(0, 6'h2C, 1, 0, 0, 16'h0010, "R11 stat2 kept");
    acc(0, 6'h29, 1, 0, 0, 16'h009A, "R11 rxb2 kept");
    @(posedge clk_i); #1;
    chk(q_tag.size() == 0, "scoreboard drained", 32'(q_tag.size()), 0);
    finish_run();
  end
endmodule